// File: doc/BRIEF.md
# Self-Timed Fall-Through Word Stack

This block is the storage core of a FIFO slice. It sits between an input register and an output register. It holds up to fourteen 4-bit words in a chain of locations, and each location carries its own occupied flag. There are no read or write pointers. A word written into the top location drops one location per clock while the location below it is free. It comes to rest at the lowest free position, so the bottom location always presents the oldest word held.

The upstream side sees a push port and a flag that says the top location is free. The downstream side sees the bottom word and a flag that says it is valid, and it removes that word with a pop strobe. An active-low master reset clears the occupancy flags only. The stored data bits are left untouched.

Several words can move on the same clock. A location also advances when the location below it is itself advancing on that edge, so a full chain shifts as one.

Top module: `fts_stack`

## Requirements
- R1: On a clock edge with `mrst_n` low, every location becomes empty: after that edge `top_free` is 1 and `bot_valid` is 0.
- R2: A push is taken only when `push_en` is 1 and `top_free` is 1 on the same edge. A push offered while `top_free` is 0 is dropped and never appears at the bottom. After a taken push, `top_free` is 0 on the next cycle.
- R3: A word pushed into an empty stack raises `bot_valid` exactly DEPTH-1 (13) clock edges after the edge that took it. At that point `bot_data` equals the pushed word.
- R4: Words leave the bottom in the order they were pushed, with none lost and none duplicated, under any timing of push and pop.
- R5: The stack holds at most DEPTH (14) words. After 14 pushes with no pop, `top_free` stays 0.
- R6: A pop (`pop_en` 1 while `bot_valid` is 1) clears `bot_valid` on the next cycle. If a word waits directly above, it enters the bottom one edge later, and `bot_valid` returns to 1 with that word.
- R7: When a full stack is popped, all remaining words shift down together on the following edge. `top_free` is therefore 1 two edges after the pop edge.
- R8: Master reset does not alter the stored data: `bot_data` keeps its value across a reset.
- R9: While `bot_valid` is 1 and no pop is given, `bot_valid` stays 1 and `bot_data` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all steps on its rising edge |
| mrst_n | input | 1 | Synchronous active-low master reset of occupancy flags |
| push_en | input | 1 | Offer `push_data` to the top location |
| push_data | input | WORD_W | Word offered for writing |
| top_free | output | 1 | Top location is empty and can take a push |
| pop_en | input | 1 | Remove the word at the bottom location |
| bot_valid | output | 1 | Bottom location holds a word |
| bot_data | output | WORD_W | Data bits of the bottom location |

## Verification
A location that keeps its flag when its word moves on shows up as a duplicated word at the bottom. The scoreboard flags it at the very next pop that presents it. A location that clears its flag while its word is blocked loses that word. The scoreboard sees the loss as a wrong value or as an empty stack when words are still expected. An error in the advance chain also shifts the 13-edge arrival time or the two-edge refill of `top_free`, and both are measured to the exact cycle. A reset that touched data bits would change `bot_data` on the first cycle after reset.

// File: rtl/fts_pkg.sv
package fts_pkg;
    parameter int WORD_W = 4;
    parameter int DEPTH  = 14;

    // Per-location control decided each cycle
    typedef struct packed {
        logic load;   // take a word from above (or from the push port)
        logic leave;  // word departs (advances down or is popped)
    } step_t;
endpackage

// File: rtl/fts_cell.sv
// One location of the chain: an occupied flag plus a data word.
module fts_cell #(
    parameter int W = fts_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  fts_pkg::step_t step,
    input  logic [W-1:0] in_data,
    output logic         occ,
    output logic [W-1:0] data
);
    typedef struct packed {
        logic         occ;
        logic [W-1:0] data;
    } loc_t;

    loc_t loc_d, loc_q;

    always_comb begin
        loc_d = loc_q;
        if (step.leave) loc_d.occ = 1'b0;
        if (step.load) begin
            loc_d.occ  = 1'b1;
            loc_d.data = in_data;
        end
    end

    // Reset clears only the flag; data bits keep their contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_q.occ <= 1'b0;
        end else begin
            loc_q <= loc_d;
        end
    end

    assign occ  = loc_q.occ;
    assign data = loc_q.data;
endmodule

// File: rtl/fts_advance.sv
// Decides which locations advance this cycle. Index 0 is the top.
// A location advances when it holds a word and the one below is empty
// or is itself advancing. The bottom never counts as vacated by a pop
// in the same cycle.
module fts_advance #(
    parameter int D = fts_pkg::DEPTH
) (
    input  logic [D-1:0] occ,
    input  logic         push_req,
    input  logic         pop_req,
    output fts_pkg::step_t steps [D]
);
    localparam int LAST = D - 1;

    logic [D-1:0] adv;   // adv[i]: location i moves to i+1
    logic         take_top;
    logic         drop_bot;

    assign adv[LAST] = 1'b0;

    generate
        for (genvar i = LAST - 1; i >= 0; i--) begin : g_adv
            if (i == LAST - 1) begin : g_edge
                assign adv[i] = occ[i] & ~occ[i+1];
            end else begin : g_mid
                assign adv[i] = occ[i] & (~occ[i+1] | adv[i+1]);
            end
        end
    endgenerate

    assign take_top = push_req & ~occ[0];
    assign drop_bot = pop_req & occ[LAST];

    generate
        for (genvar i = 0; i < D; i++) begin : g_step
            if (i == 0) begin : g_top
                assign steps[i].load  = take_top;
                assign steps[i].leave = (LAST == 0) ? drop_bot : adv[i];
            end else if (i == LAST) begin : g_bot
                assign steps[i].load  = adv[i-1];
                assign steps[i].leave = drop_bot;
            end else begin : g_mid
                assign steps[i].load  = adv[i-1];
                assign steps[i].leave = adv[i];
            end
        end
    endgenerate
endmodule

// File: rtl/fts_stack.sv
module fts_stack #(
    parameter int WORD_W = fts_pkg::WORD_W,
    parameter int DEPTH  = fts_pkg::DEPTH
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              push_en,
    input  logic [WORD_W-1:0] push_data,
    output logic              top_free,
    input  logic              pop_en,
    output logic              bot_valid,
    output logic [WORD_W-1:0] bot_data
);
    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0]  occ_w;
    logic [WORD_W-1:0] data_w [DEPTH];
    fts_pkg::step_t    steps_w [DEPTH];

    fts_advance #(.D(DEPTH)) u_adv (
        .occ      (occ_w),
        .push_req (push_en),
        .pop_req  (pop_en),
        .steps    (steps_w)
    );

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_loc
            logic [WORD_W-1:0] src;
            if (i == 0) begin : g_src_top
                assign src = push_data;
            end else begin : g_src_chain
                assign src = data_w[i-1];
            end
            fts_cell #(.W(WORD_W)) u_cell (
                .clk     (clk),
                .rst_n   (mrst_n),
                .step    (steps_w[i]),
                .in_data (src),
                .occ     (occ_w[i]),
                .data    (data_w[i])
            );
        end
    endgenerate

    assign top_free  = ~occ_w[0];
    assign bot_valid = occ_w[LAST];
    assign bot_data  = data_w[LAST];
endmodule

// File: rtl/fts_stack_chk.sv
module fts_stack_chk #(
    parameter int W = fts_pkg::WORD_W,
    parameter int D = fts_pkg::DEPTH
) (
    input logic         clk,
    input logic         rst_n,
    input logic         push_en,
    input logic         top_free,
    input logic         pop_en,
    input logic         bot_valid,
    input logic [W-1:0] bot_data,
    input logic [D-1:0] occ
);
    localparam int CW = $clog2(D + 1) + 1;

    logic [CW-1:0] held_q;
    logic          took, gave;

    assign took = push_en & top_free;
    assign gave = pop_en & bot_valid;

    // Word count from port activity alone
    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_q + CW'(took) - CW'(gave);
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (top_free && !bot_valid));

    assert_push_takes_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> !top_free);

    assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q == CW'(D)) |-> !top_free);

    assert_count_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
        CW'($countones(occ)) == held_q);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        held_q <= CW'(D));

    assert_pop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        gave |=> !bot_valid);

    assert_full_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gave && held_q == CW'(D)) |=> ##1 top_free);

    assert_bottom_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bot_valid && !pop_en) |=> (bot_valid && $stable(bot_data)));
endmodule

bind fts_stack fts_stack_chk #(.W(WORD_W), .D(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (mrst_n),
    .push_en   (push_en),
    .top_free  (top_free),
    .pop_en    (pop_en),
    .bot_valid (bot_valid),
    .bot_data  (bot_data),
    .occ       (occ_w)
);

// File: tb/fts_stack_bench.sv
module fts_stack_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W  = 4;
    localparam int D  = 14;
    localparam int WD = 200000;

    logic         clk = 1'b0;
    logic         mrst_n = 1'b0;
    logic         push_en = 1'b0;
    logic [W-1:0] push_data = '0;
    logic         pop_en = 1'b0;
    logic         top_free, bot_valid;
    logic [W-1:0] bot_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] sb [$];
    bit drv_en = 0, mon_en = 0;
    int push_pct = 0, pop_pct = 0;

    always #2.5 clk = ~clk;

    fts_stack #(.WORD_W(W), .DEPTH(D)) u_fts_stack (
        .clk(clk), .mrst_n(mrst_n), .push_en(push_en), .push_data(push_data),
        .top_free(top_free), .pop_en(pop_en), .bot_valid(bot_valid), .bot_data(bot_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Driver: pushes into the design and records each taken word
    initial forever begin
        @(negedge clk);
        if (drv_en) begin
            if (top_free && ($urandom_range(99) < push_pct)) begin
                push_data = W'($urandom_range(15));
                push_en   = 1'b1;
                sb.push_back(push_data);
            end else begin
                push_en = 1'b0;
            end
        end
    end

    // Monitor: pops and compares against the scoreboard
    initial forever begin
        @(negedge clk);
        if (mon_en) begin
            chk(sb.size() <= D, "R5 occupancy", sb.size(), D);
            if (bot_valid && ($urandom_range(99) < pop_pct)) begin
                if (sb.size() == 0) begin
                    chk(0, "R4 extra word", bot_data, -1);
                end else begin
                    chk(bot_data == sb[0], "R4 order", bot_data, sb[0]);
                    void'(sb.pop_front());
                end
                pop_en = 1'b1;
            end else begin
                pop_en = 1'b0;
            end
        end
    end

    initial begin
        #(WD * 5.0);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [W-1:0] fill [$];
        int taken;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(top_free == 1'b1, "R1 top_free", top_free, 1);
        chk(bot_valid == 1'b0, "R1 bot_valid", bot_valid, 0);
        mrst_n = 1'b1;
        @(negedge clk);

        // R3 latency through an empty stack
        push_en = 1'b1; push_data = 4'h6;
        @(negedge clk);
        push_en = 1'b0;
        chk(top_free == 1'b0, "R2 top busy after push", top_free, 0);
        for (int j = 0; j < D - 1; j++) begin
            chk(bot_valid == 1'b0, "R3 early arrival", bot_valid, 0);
            @(negedge clk);
        end
        chk(bot_valid == 1'b1, "R3 arrival edge", bot_valid, 1);
        chk(bot_data == 4'h6, "R3 data", bot_data, 6);
        pop_en = 1'b1;
        @(negedge clk);
        pop_en = 1'b0;
        chk(bot_valid == 1'b0, "R6 pop clears", bot_valid, 0);

        // R5 fill to capacity
        taken = 0;
        while (taken < D) begin
            if (top_free) begin
                push_data = W'(taken + 1);
                push_en = 1'b1;
                fill.push_back(push_data);
                taken++;
            end else begin
                push_en = 1'b0;
            end
            @(negedge clk);
        end
        push_en = 1'b0;
        repeat (30) @(negedge clk);
        chk(top_free == 1'b0, "R5 full", top_free, 0);
        chk(bot_data == fill[0], "R9 bottom held", bot_data, fill[0]);
        // R2 offer while full
        push_en = 1'b1; push_data = 4'hF;
        @(negedge clk);
        push_en = 1'b0;
        chk(top_free == 1'b0, "R2 rejected push", top_free, 0);

        // R6 / R7 pop a full stack
        chk(bot_data == fill[0], "R4 first out", bot_data, fill[0]);
        void'(fill.pop_front());
        pop_en = 1'b1;
        @(negedge clk);
        pop_en = 1'b0;
        chk(bot_valid == 1'b0, "R6 gap cycle", bot_valid, 0);
        chk(top_free == 1'b0, "R7 not yet free", top_free, 0);
        @(negedge clk);
        chk(bot_valid == 1'b1, "R6 refill", bot_valid, 1);
        chk(bot_data == fill[0], "R6 refill data", bot_data, fill[0]);
        chk(top_free == 1'b1, "R7 whole chain shifted", top_free, 1);

        // Drain through the scoreboard
        sb = fill;
        pop_pct = 100; mon_en = 1;
        repeat (60) @(negedge clk);
        mon_en = 0;
        @(negedge clk);
        pop_en = 1'b0;
        chk(sb.size() == 0, "R4 all words out", sb.size(), 0);
        repeat (20) @(negedge clk);
        chk(bot_valid == 1'b0, "R2 rejected word absent", bot_valid, 0);

        // R8 reset leaves data
        push_en = 1'b1; push_data = 4'hA;
        @(negedge clk);
        push_en = 1'b0;
        repeat (20) @(negedge clk);
        chk(bot_data == 4'hA, "R8 word at bottom", bot_data, 10);
        mrst_n = 1'b0;
        repeat (2) @(negedge clk);
        mrst_n = 1'b1;
        chk(bot_valid == 1'b0, "R1 valid cleared", bot_valid, 0);
        chk(top_free == 1'b1, "R1 top freed", top_free, 1);
        chk(bot_data == 4'hA, "R8 data kept", bot_data, 10);
        @(negedge clk);

        // Random push/pop timing, R4 and R5
        sb.delete();
        push_pct = 55; pop_pct = 45;
        drv_en = 1; mon_en = 1;
        repeat (3000) @(negedge clk);
        drv_en = 0;
        @(negedge clk);
        push_en = 1'b0;
        pop_pct = 100;
        repeat (100) @(negedge clk);
        mon_en = 0;
        @(negedge clk);
        pop_en = 1'b0;
        chk(sb.size() == 0, "R4 random drain", sb.size(), 0);
        @(negedge clk);
        chk(bot_valid == 1'b0, "R4 nothing left", bot_valid, 0);

        finish_run();
    end
endmodule